// File: doc/BRIEF.md
# PCIe Gen2 Speed Upshift Controller

This block is the per-port policy that decides when the link training state machine should be asked to move a trained link from 2.5 GT/s to 5.0 GT/s. It watches an abstracted LTSSM sub-state code, the data-link-active flag, the rate bits that the link partner sends in its training sets and the rate that the PHY has negotiated. From these it drives one speed-change request together with the rate it asks for. It also holds the software target speed and reports the current link speed for every function of the port. A status bit tells software that a retrain it started has completed a speed change.

A port strap selects the role. A downstream-role port raises the link by itself: once the data link comes up, and again whenever the partner newly offers 5.0 GT/s during Recovery. An upstream-role port only acts on a software retrain. The first upgrade that the port starts by itself is kept out of the status bit.

Rate encoding: 1 means 2.5 GT/s and 2 means 5.0 GT/s. Bit 1 of the partner rate bits means the partner offers 5.0 GT/s. The LTSSM codes are 0 Detect, 1 Polling, 2 Configuration (other), 3 Configuration.Complete, 4 L0, 5 Recovery.RcvrLock, 6 Recovery.RcvrCfg and 7 Recovery.Idle.

Top module: `pcie_gen2_upshift`

## Requirements
- R1: In every cycle that the LTSSM code is 0 (Detect), the next cycle shows current speed 1 and no request. Any pending Recovery upgrade is also dropped.
- R2: A downstream-role port raises a request for rate 2 in the cycle after dl_active rises while the LTSSM is in L0 (4). This needs current speed 1, target 2, a recorded partner capability of 5.0 GT/s and init_upg_dis low.
- R3: An upstream-role port never raises a request unless sw_retrain is pulsed. If init_upg_dis is high, a downstream port also makes no request when the data link comes up.
- R4: The partner's 5.0 GT/s bit is recorded on each cycle in which the LTSSM enters code 3 or code 6 from any other code. The newest record replaces the older one.
- R5: A sw_retrain pulse raises a request when the recorded capability is 5.0 GT/s and the target differs from the current speed. The requested rate equals the target speed.
- R6: A downstream port at 2.5 GT/s arms an upgrade when it enters code 6 and the partner bit goes from not offered to offered. With target 2, it requests rate 2 in the first L0 cycle that follows.
- R7: bw_sts sets when a request raised by sw_retrain completes with a negotiated rate that differs from the previous current speed. An autonomous upgrade never sets it. Writing bw_sts_w1c high clears it, and a set in the same cycle wins.
- R8: The target speed resets to 2 and takes tls_wdata when tls_we is high. adv_rates always reads 3, which offers both rates.
- R9: At most one request is outstanding. It holds, with a stable rate, until the LTSSM next enters L0 (or hits Detect). Triggers that arrive while it is held are ignored.
- R10: In every L0 cycle the current speed takes neg_rate. All NUM_FUNC two-bit slices of cur_speed_fn carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dsp_role | input | 1 | 1 = downstream-role port, 0 = upstream-role |
| ltssm_st | input | 3 | Abstracted LTSSM sub-state code |
| dl_active | input | 1 | Data link layer active |
| partner_rates | input | 2 | Rates offered by the partner in training sets |
| neg_rate | input | 2 | Rate negotiated by the PHY |
| tls_we | input | 1 | Target speed write strobe |
| tls_wdata | input | 2 | Target speed write value |
| init_upg_dis | input | 1 | Disables the upgrade when the data link comes up |
| sw_retrain | input | 1 | Software retrain strobe |
| bw_sts_w1c | input | 1 | Write-one-to-clear for bw_sts |
| adv_rates | output | 2 | Rates this port offers |
| tgt_speed | output | 2 | Target link speed |
| upg_req | output | 1 | Speed-change request to the LTSSM |
| upg_rate | output | 2 | Rate requested |
| cur_speed_fn | output | 2*NUM_FUNC | Current link speed, one slice per function |
| bw_sts | output | 1 | Software-directed speed change completed |

## Verification
The hardest case to reach from the ports is the Recovery-driven upgrade of R6. It needs a link already trained at 2.5 GT/s with no 5.0 GT/s record. Then a later entry to Recovery.RcvrCfg must carry the partner's new offer, and it must be followed by a return to L0 with no Detect in between. The bench walks there with a directed training run in which the partner offers only 2.5 GT/s, then a Recovery pass in which it offers both. A long random phase then mixes sub-state codes, partner bits, retrains and target writes. Each cycle is compared with a cycle-level model kept in the bench, so overlaps also get exercised: a trigger during an outstanding request, a capture that removes the record, a clear in the same cycle as a set.

// File: rtl/pcie_gen2_upshift.sv
module pcie_gen2_upshift #(
  parameter int NUM_FUNC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dsp_role,
  input  logic [2:0]            ltssm_st,
  input  logic                  dl_active,
  input  logic [1:0]            partner_rates,
  input  logic [1:0]            neg_rate,
  input  logic                  tls_we,
  input  logic [1:0]            tls_wdata,
  input  logic                  init_upg_dis,
  input  logic                  sw_retrain,
  input  logic                  bw_sts_w1c,
  output logic [1:0]            adv_rates,
  output logic [1:0]            tgt_speed,
  output logic                  upg_req,
  output logic [1:0]            upg_rate,
  output logic [2*NUM_FUNC-1:0] cur_speed_fn,
  output logic                  bw_sts
);
  localparam logic [2:0] ST_DET = 3'd0, ST_CFGC = 3'd3, ST_L0 = 3'd4, ST_RCFG = 3'd6;
  localparam logic [1:0] GEN1 = 2'd1, GEN2 = 2'd2;

  logic [2:0] prev_st;
  logic       dl_q, cap_g2, sw_own, rec_pend;
  logic [1:0] cur;

  wire in_det   = ltssm_st == ST_DET;
  wire in_l0    = ltssm_st == ST_L0;
  wire l0_entry = in_l0 && prev_st != ST_L0;
  wire cap_evt  = (ltssm_st == ST_CFGC || ltssm_st == ST_RCFG) && prev_st != ltssm_st;
  wire dl_rise  = dl_active && !dl_q;
  wire idle     = !upg_req && !in_det;
  wire at_g1    = cur == GEN1;
  wire tgt_g2   = tgt_speed == GEN2;

  wire trig_sw   = idle && sw_retrain && cap_g2 && tgt_speed != cur;
  wire trig_init = idle && dsp_role && dl_rise && in_l0 && tgt_g2 && cap_g2 && !init_upg_dis && at_g1;
  wire trig_rec  = idle && dsp_role && rec_pend && in_l0 && tgt_g2 && at_g1;
  wire trig_any  = trig_sw || trig_init || trig_rec;
  wire done      = upg_req && l0_entry;
  wire arm_rec   = dsp_role && cap_evt && ltssm_st == ST_RCFG && partner_rates[1] && !cap_g2 && at_g1;

  assign adv_rates    = 2'b11;
  assign cur_speed_fn = {NUM_FUNC{cur}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_st   <= ST_DET;
      dl_q      <= 1'b0;
      cap_g2    <= 1'b0;
      tgt_speed <= GEN2;
      cur       <= GEN1;
      upg_req   <= 1'b0;
      upg_rate  <= GEN1;
      sw_own    <= 1'b0;
      rec_pend  <= 1'b0;
      bw_sts    <= 1'b0;
    end else begin
      prev_st <= ltssm_st;
      dl_q    <= dl_active;
      if (cap_evt) cap_g2 <= partner_rates[1];
      if (tls_we) tgt_speed <= tls_wdata;

      if (in_det) cur <= GEN1;
      else if (in_l0) cur <= neg_rate;

      if (in_det || done) upg_req <= 1'b0;
      else if (trig_any) upg_req <= 1'b1;

      if (trig_any) begin
        upg_rate <= tgt_speed;
        sw_own   <= trig_sw;
      end else if (in_det) sw_own <= 1'b0;

      if (in_det || trig_rec || cur == GEN2) rec_pend <= 1'b0;
      else if (arm_rec) rec_pend <= 1'b1;

      if (done && sw_own && neg_rate != cur) bw_sts <= 1'b1;
      else if (bw_sts_w1c) bw_sts <= 1'b0;
    end
  end
endmodule

module pcie_gen2_upshift_chk #(
  parameter int NUM_FUNC = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dsp_role,
  input logic [2:0]            ltssm_st,
  input logic                  sw_retrain,
  input logic                  upg_req,
  input logic [1:0]            upg_rate,
  input logic [2*NUM_FUNC-1:0] cur_speed_fn,
  input logic                  bw_sts
);
  // R1
  detect_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_st == 3'd0 |=> (cur_speed_fn[1:0] == 2'd1 && !upg_req));
  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req && ltssm_st != 3'd4 && ltssm_st != 3'd0) |=> upg_req);
  // R9
  rate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upg_req |=> (!upg_req || $stable(upg_rate)));
  // R3
  usp_no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_role && !sw_retrain && !upg_req) |=> !upg_req);
  // R7
  bw_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upg_req && !bw_sts) |=> !bw_sts);
endmodule

bind pcie_gen2_upshift pcie_gen2_upshift_chk #(.NUM_FUNC(NUM_FUNC)) i_chk (.*);

// File: tb/test_pcie_gen2_upshift.sv
module test_pcie_gen2_upshift;
  localparam int NF = 4;
  logic clk = 0, rst_n = 0;
  logic dsp_role = 1, dl_active = 0, tls_we = 0, init_upg_dis = 0, sw_retrain = 0, bw_sts_w1c = 0;
  logic [2:0] ltssm_st = 0;
  logic [1:0] partner_rates = 2'b01, neg_rate = 2'd1, tls_wdata = 2'd2;
  logic [1:0] adv_rates, tgt_speed, upg_rate;
  logic upg_req, bw_sts;
  logic [2*NF-1:0] cur_speed_fn;
  int n_vec = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  pcie_gen2_upshift #(.NUM_FUNC(NF)) i_pcie_gen2_upshift (.*);

  logic [2:0] m_prev; logic m_dlq, m_cap, m_req, m_own, m_pend, m_bw;
  logic [1:0] m_tgt, m_cur, m_rate;

  task automatic chk(input int act, input int exp, input string tag);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic slices_equal(input logic [2*NF-1:0] v);
    for (int i = 1; i < NF; i++) if (v[2*i +: 2] != v[1:0]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_reset();
    m_prev = 0; m_dlq = 0; m_cap = 0; m_req = 0; m_own = 0; m_pend = 0; m_bw = 0;
    m_tgt = 2; m_cur = 1; m_rate = 1;
  endtask

  task automatic step();
    logic det, l0, l0e, ent, free, ts, ta, tr, done;
    logic n_req, n_own, n_pend, n_bw; logic [1:0] n_cur, n_rate;
    det  = ltssm_st == 0; l0 = ltssm_st == 4; l0e = l0 && m_prev != 4;
    ent  = (ltssm_st == 3 || ltssm_st == 6) && m_prev != ltssm_st;
    free = !m_req && !det;
    ts   = free && sw_retrain && m_cap && m_tgt != m_cur;
    ta   = free && dsp_role && dl_active && !m_dlq && l0 && m_tgt == 2 && m_cap && !init_upg_dis && m_cur == 1;
    tr   = free && dsp_role && m_pend && l0 && m_tgt == 2 && m_cur == 1;
    done = m_req && l0e;
    n_req  = det ? 0 : done ? 0 : (ts || ta || tr) ? 1 : m_req;
    n_own  = (ts || ta || tr) ? ts : det ? 0 : m_own;
    n_rate = (ts || ta || tr) ? m_tgt : m_rate;
    n_pend = (det || tr || m_cur == 2) ? 0 :
             (dsp_role && ent && ltssm_st == 6 && partner_rates[1] && !m_cap && m_cur == 1) ? 1 : m_pend;
    n_cur  = det ? 2'd1 : l0 ? neg_rate : m_cur;
    n_bw   = (done && m_own && neg_rate != m_cur) ? 1 : bw_sts_w1c ? 0 : m_bw;
    if (ent) m_cap = partner_rates[1];
    if (tls_we) m_tgt = tls_wdata;
    m_req = n_req; m_own = n_own; m_rate = n_rate; m_pend = n_pend; m_cur = n_cur; m_bw = n_bw;
    m_prev = ltssm_st; m_dlq = dl_active;
    @(posedge clk); cyc++;
    #1;
    chk(upg_req, m_req, "R9 model request");
    if (m_req) chk(upg_rate, m_rate, "R5 model rate");
    chk(cur_speed_fn[1:0], m_cur, "R10 model speed");
    chk(bw_sts, m_bw, "R7 model status");
    chk(tgt_speed, m_tgt, "R8 model target");
  endtask

  task automatic go(input logic [2:0] s);
    ltssm_st = s; step();
  endtask

  task automatic train(input logic [1:0] pr);
    dl_active = 0; neg_rate = 1; partner_rates = pr;
    go(0); go(1); go(2); go(3); go(4); go(4);
    dl_active = 1; go(4);
  endtask

  task automatic recover(input logic [1:0] pr, input logic [1:0] nr);
    partner_rates = pr; go(5); go(6); go(7); neg_rate = nr; go(4);
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(upg_req, 0, "R9 reset request");
    chk(cur_speed_fn[1:0], 1, "R10 reset speed");
    chk(bw_sts, 0, "R7 reset status");
    chk(tgt_speed, 2, "R8 reset target");
    chk(adv_rates, 3, "R8 advertised rates");

    // R2 downstream auto upgrade, then completion, no status
    dsp_role = 1; train(2'b11);
    chk(upg_req, 1, "R2 auto request"); chk(upg_rate, 2, "R2 auto rate");
    go(5); chk(upg_req, 1, "R9 held in recovery");
    recover(2'b11, 2);
    chk(upg_req, 0, "R9 released at L0");
    chk(cur_speed_fn[1:0], 2, "R10 speed now 5.0");
    chk(slices_equal(cur_speed_fn), 1, "R10 all functions equal");
    chk(bw_sts, 0, "R7 no status for auto upgrade");
    go(0); chk(cur_speed_fn[1:0], 1, "R1 detect resets speed");

    // R3 upstream role, and disable bit
    dsp_role = 0; train(2'b11); go(4);
    chk(upg_req, 0, "R3 upstream no auto");
    dsp_role = 1; init_upg_dis = 1; train(2'b11);
    chk(upg_req, 0, "R3 init disable");
    init_upg_dis = 0;

    // R6 recovery advertisement
    train(2'b01); chk(upg_req, 0, "R2 partner gen1 only");
    recover(2'b11, 1);
    chk(upg_req, 1, "R6 recovery upgrade"); chk(upg_rate, 2, "R6 rate");
    recover(2'b11, 2); chk(upg_req, 0, "R9 recovery request done");

    // R5/R7 software retrain on upstream port
    dsp_role = 0; train(2'b11);
    sw_retrain = 1; go(4); sw_retrain = 0;
    chk(upg_req, 1, "R5 retrain request");
    tls_we = 1; tls_wdata = 1; sw_retrain = 1; go(4); tls_we = 0; sw_retrain = 0;
    chk(upg_rate, 2, "R9 second trigger ignored");
    tls_we = 1; tls_wdata = 2; go(4); tls_we = 0;
    recover(2'b11, 2);
    chk(bw_sts, 1, "R7 status after sw change");
    bw_sts_w1c = 1; go(4); bw_sts_w1c = 0;
    chk(bw_sts, 0, "R7 write one clears");

    // R4 latest capture replaces earlier
    train(2'b11);
    recover(2'b01, 1);
    sw_retrain = 1; go(4); sw_retrain = 0;
    chk(upg_req, 0, "R4 newer capture removes 5.0");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      ltssm_st = (r == 0) ? 3'd0 : 3'($urandom_range(1, 7));
      dsp_role = ($urandom_range(0, 7) != 0);
      dl_active = $urandom_range(0, 1);
      partner_rates = 2'($urandom_range(0, 3));
      neg_rate = 2'($urandom_range(1, 2));
      init_upg_dis = ($urandom_range(0, 5) == 0);
      sw_retrain = ($urandom_range(0, 7) == 0);
      bw_sts_w1c = ($urandom_range(0, 7) == 0);
      tls_we = ($urandom_range(0, 15) == 0);
      tls_wdata = 2'($urandom_range(1, 2));
      step();
      chk(slices_equal(cur_speed_fn), 1, "R10 random slices");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule